// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block turns bytes written by software into asynchronous serial frames on a single output line. A one-byte holding stage sits in front of the shift stage. The holding stage accepts the next byte while the current frame is still going out, so the line can run frames back to back with only a one-cycle gap between them. Each frame has one start bit, eight data bits sent least significant bit first, an optional ninth bit, and one stop bit. The ninth bit carries either a value supplied by software or a parity bit that the block computes.

An external baud tick sets the timing. Every bit lasts a fixed number of ticks. The block reports whether the holding stage is free. It also raises a sticky transmit-done flag when the stop bit begins, and that flag stays set until software clears it. The ninth-bit settings are sampled when a byte moves into the shift stage. A change to them during a frame therefore affects only later frames.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset the line is high, `hold_empty` is 1 and `tx_done` is 0.
- R2: A byte written while no frame is in progress clears `hold_empty` for exactly one cycle. The byte then moves into the shift stage, `hold_empty` returns to 1, and the start bit appears on the line in the following cycle.
- R3: A byte written during a frame keeps `hold_empty` at 0 until the current frame's stop bit has ended. That byte is then sent as the next frame.
- R4: A frame is a start bit of 0, then the eight data bits least significant bit first, then the optional ninth bit, then a stop bit of 1. Each bit lasts OVS (default 16) baud ticks, and the line stays high between frames.
- R5: When `xbit_en` is 1 and `par_en` is 0, the ninth bit is the value of `xbit_val`.
- R6: When `par_en` is 1, the ninth bit follows `par_type`. The codes are 2'b00 for odd parity, where the data bits plus the ninth bit hold an odd number of ones, 2'b01 for even parity, 2'b10 for a constant 1, and 2'b11 for a constant 0.
- R7: When `par_en` and `xbit_en` are both 1, the parity bit is sent and `xbit_val` is ignored. When both are 0, no ninth bit is sent.
- R8: `tx_done` rises in the first cycle of the stop bit, not at its end, and it stays at 1 until `done_clr` is asserted.
- R9: When `done_clr` is asserted in the same cycle that a stop bit begins, `tx_done` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | DW | Byte to transmit |
| xbit_en | input | 1 | Enables the software-supplied ninth bit |
| par_en | input | 1 | Enables the hardware parity bit, which takes priority over `xbit_en` |
| par_type | input | 2 | Parity mode: 00 odd, 01 even, 10 constant 1, 11 constant 0 |
| xbit_val | input | 1 | Value sent as the ninth bit in extra-bit mode |
| baud_tick | input | 1 | One-cycle pulse, one per oversample period |
| done_clr | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | 1 when the holding stage can accept a byte |
| tx_done | output | 1 | Sticky flag that rises at the start of each stop bit |

## Verification
All 256 byte values are sent with no ninth bit. Reading each decoded frame back catches bit-order, framing and shift errors that a single pattern could hide. Each parity code is then tried on a spread of bytes with both odd and even numbers of ones, and extra-bit mode is tried with both values of `xbit_val` while parity is both on and off. This separates the four parity codes from one another and shows that parity wins over the extra bit. Further tests write a second byte during a frame, hold `done_clr` across a stop-bit entry, and halve the tick rate. These show that the holding stage waits for the frame to end, that a set beats a clear on `tx_done`, and that bit length follows ticks rather than clock cycles.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    TXS_IDLE  = 3'd0,
    TXS_START = 3'd1,
    TXS_DATA  = 3'd2,
    TXS_NINTH = 3'd3,
    TXS_STOP  = 3'd4
  } txs_e;

  localparam logic [1:0] PT_ODD   = 2'b00;
  localparam logic [1:0] PT_EVEN  = 2'b01;
  localparam logic [1:0] PT_MARK  = 2'b10;
  localparam logic [1:0] PT_SPACE = 2'b11;

  // ninth bit in parity mode; odd_ones is the XOR of all data bits
  function automatic logic par_bit(input logic [1:0] ptype, input logic odd_ones);
    logic r;
    case (ptype)
      PT_ODD:   r = ~odd_ones;
      PT_EVEN:  r = odd_ones;
      PT_MARK:  r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  input  logic          shift_idle,
  output logic          full,
  output logic [DW-1:0] data
);

  logic          full_d;
  logic [DW-1:0] data_d;
  logic          full_q;
  logic [DW-1:0] data_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (wr_en) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  AST_HOLD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && shift_idle && !wr_en) |=> !full_q); // R2

  AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !shift_idle) |=> full_q); // R3

endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic bit_end
);

  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign bit_end = run && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || bit_end) cnt_d = '0;
    else if (run && tick)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          xbit_en,
  input  logic          par_en,
  input  logic [1:0]    par_type,
  input  logic          xbit_val,
  input  logic          bit_end,
  output logic          take,
  output logic          idle,
  output logic          stop_entry,
  output logic          txd
);

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  txs_e          st_q, st_d;
  logic [BW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          nen_q, nen_d;
  logic          nval_q, nval_d;

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    nen_d      = nen_q;
    nval_d     = nval_q;
    take       = 1'b0;
    stop_entry = 1'b0;
    case (st_q)
      TXS_IDLE: begin
        if (hold_full) begin
          take   = 1'b1;
          st_d   = TXS_START;
          sh_d   = hold_data;
          nen_d  = par_en | xbit_en;
          nval_d = par_en ? par_bit(par_type, ^hold_data) : xbit_val;
        end
      end
      TXS_START: begin
        if (bit_end) begin
          st_d  = TXS_DATA;
          idx_d = '0;
        end
      end
      TXS_DATA: begin
        if (bit_end) begin
          sh_d = sh_q >> 1;
          if (idx_q == LAST_BIT) begin
            if (nen_q) begin
              st_d = TXS_NINTH;
            end else begin
              st_d       = TXS_STOP;
              stop_entry = 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      TXS_NINTH: begin
        if (bit_end) begin
          st_d       = TXS_STOP;
          stop_entry = 1'b1;
        end
      end
      TXS_STOP: begin
        if (bit_end) st_d = TXS_IDLE;
      end
      default: st_d = TXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TXS_IDLE;
      idx_q  <= '0;
      sh_q   <= '0;
      nen_q  <= 1'b0;
      nval_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      nen_q  <= nen_d;
      nval_q <= nval_d;
    end
  end

  always_comb begin
    case (st_q)
      TXS_START: txd = 1'b0;
      TXS_DATA:  txd = sh_q[0];
      TXS_NINTH: txd = nval_q;
      default:   txd = 1'b1;
    endcase
  end

  assign idle = (st_q == TXS_IDLE);

  AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd); // R2

  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_end && !take) |=> $stable(txd)); // R4

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> txd); // R4

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          xbit_en,
  input  logic          par_en,
  input  logic [1:0]    par_type,
  input  logic          xbit_val,
  input  logic          baud_tick,
  input  logic          done_clr,
  output logic          txd,
  output logic          hold_empty,
  output logic          tx_done
);

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          take;
  logic          idle;
  logic          stop_entry;
  logic          bit_end;
  logic          done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  sertx_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .take       (take),
    .shift_idle (idle),
    .full       (hold_full),
    .data       (hold_data)
  );

  sertx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .restart (take),
    .run     (!idle),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  sertx_shift #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .xbit_en    (xbit_en),
    .par_en     (par_en),
    .par_type   (par_type),
    .xbit_val   (xbit_val),
    .bit_end    (bit_end),
    .take       (take),
    .idle       (idle),
    .stop_entry (stop_entry),
    .txd        (txd)
  );

  always_comb begin
    done_d = done_q;
    if (stop_entry)    done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) done_q <= 1'b0;
    else          done_q <= done_d;
  end

  assign tx_done    = done_q;
  assign hold_empty = !hold_full;

  AST_DONE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_s_n)
    stop_entry |=> tx_done); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tx_done && !done_clr) |=> tx_done); // R8

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stop_entry && done_clr) |=> tx_done); // R9

  AST_RESET_LINE: assert property (@(posedge clk)
    !rst_s_n |-> (txd && hold_empty && !tx_done)); // R1

endmodule

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       xbit_en, par_en, xbit_val;
  logic [1:0] par_type;
  logic       baud_tick;
  logic       done_clr;
  logic       txd, hold_empty, tx_done;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_ph = 0;

  sertx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xbit_en(xbit_en), .par_en(par_en), .par_type(par_type),
    .xbit_val(xbit_val), .baud_tick(baud_tick), .done_clr(done_clr),
    .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tick_div <= 1) baud_tick = 1'b1;
    else begin
      baud_tick = (tick_ph == 0);
      tick_ph = (tick_ph + 1) % tick_div;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_ninth(input logic [7:0] d, input logic pe,
                                     input logic [1:0] pt, input logic xv);
    logic ones;
    ones = 1'b0;
    for (int i = 0; i < 8; i++) ones = ones ^ d[i];
    if (pe) begin
      case (pt)
        2'b00: return ~ones;
        2'b01: return ones;
        2'b10: return 1'b1;
        default: return 1'b0;
      endcase
    end
    return xv;
  endfunction

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
  endtask

  task automatic rx_frame(input bit has9, output logic [7:0] d, output logic b9,
                          output logic stp, output logic he_start, output logic he_stop,
                          output logic dn_before, output logic dn_stop);
    while (txd !== 1'b0) @(negedge clk);
    he_start = hold_empty;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    dn_before = tx_done;
    b9 = 1'b0;
    if (has9) begin
      repeat (16) @(negedge clk);
      b9 = txd;
      dn_before = tx_done;
    end
    repeat (16) @(negedge clk);
    stp = txd;
    he_stop = hold_empty;
    dn_stop = tx_done;
  endtask

  task automatic send_check(input logic [7:0] d, input logic xe, input logic pe,
                            input logic [1:0] pt, input logic xv);
    logic [7:0] rd;
    logic b9, stp, hs, hp, db, ds, eb;
    bit has9;
    string ntag;
    xbit_en = xe; par_en = pe; par_type = pt; xbit_val = xv;
    has9 = pe | xe;
    pulse_clr();
    write_byte(d);
    check(hold_empty == 1'b0, "R2 hold_empty low after write", hold_empty, 0);
    rx_frame(has9, rd, b9, stp, hs, hp, db, ds);
    check(hs == 1'b1, "R2 hold_empty back at start bit", hs, 1);
    check(rd == d, "R4 data bits", rd, d);
    check(stp == 1'b1, "R4 stop bit", stp, 1);
    check(db == 1'b0 && ds == 1'b1, "R8 done rises at stop start", {db, ds}, 2'b01);
    if (has9) begin
      eb = exp_ninth(d, pe, pt, xv);
      ntag = pe ? (xe ? "R7 parity over extra bit" : "R6 parity bit") : "R5 extra bit";
      check(b9 == eb, ntag, b9, eb);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic b9, stp, hs, hp, db, ds;
    int lowcnt;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; xbit_en = 1'b0; par_en = 1'b0;
    par_type = 2'b00; xbit_val = 1'b0; done_clr = 1'b0; baud_tick = 1'b0;
    repeat (4) @(negedge clk);
    check(txd == 1'b1 && hold_empty == 1'b1 && tx_done == 1'b0,
          "R1 reset state", {txd, hold_empty, tx_done}, 3'b110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd == 1'b1 && hold_empty == 1'b1 && tx_done == 1'b0,
          "R1 state after release", {txd, hold_empty, tx_done}, 3'b110);

    // R4: all bytes, no ninth bit
    for (int v = 0; v < 256; v++) send_check(8'(v), 1'b0, 1'b0, 2'b00, 1'b0);

    // R6: every parity code on a spread of bytes
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 32; k++) send_check(8'(k * 37 + 5), 1'b0, 1'b1, 2'(t), 1'b0);

    // R5 and R7: extra bit alone, then with parity enabled
    for (int k = 0; k < 8; k++) begin
      send_check(8'(k * 29 + 3), 1'b1, 1'b0, 2'b00, 1'b0);
      send_check(8'(k * 29 + 3), 1'b1, 1'b0, 2'b00, 1'b1);
      send_check(8'(k * 53 + 1), 1'b1, 1'b1, 2'(k), 1'b1);
      send_check(8'(k * 53 + 1), 1'b1, 1'b1, 2'(k), 1'b0);
    end

    // R8: the flag persists with no clear
    repeat (60) @(negedge clk);
    check(tx_done == 1'b1, "R8 done sticky", tx_done, 1);

    // R3: second byte written during a frame
    xbit_en = 1'b0; par_en = 1'b0;
    write_byte(8'hA5);
    fork
      rx_frame(1'b0, rd, b9, stp, hs, hp, db, ds);
      begin
        repeat (30) @(negedge clk);
        write_byte(8'h3C);
        check(hold_empty == 1'b0, "R3 holding stage occupied", hold_empty, 0);
        repeat (60) @(negedge clk);
        check(hold_empty == 1'b0, "R3 byte still waiting", hold_empty, 0);
      end
    join
    check(rd == 8'hA5, "R3 first frame", rd, 8'hA5);
    check(hp == 1'b0, "R3 waits through stop bit", hp, 0);
    rx_frame(1'b0, rd, b9, stp, hs, hp, db, ds);
    check(hs == 1'b1, "R3 hold freed at next start", hs, 1);
    check(rd == 8'h3C, "R3 queued byte sent", rd, 8'h3C);
    repeat (20) @(negedge clk);

    // R9: clear held while the stop bit begins
    @(negedge clk);
    done_clr = 1'b1;
    write_byte(8'h00);
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    check(tx_done == 1'b1, "R9 set wins over clear", tx_done, 1);
    @(negedge clk);
    check(tx_done == 1'b0, "R8 clear takes effect after", tx_done, 0);
    done_clr = 1'b0;
    repeat (200) @(negedge clk);

    // R4: bit length in ticks
    write_byte(8'hFF);
    while (txd !== 1'b0) @(negedge clk);
    lowcnt = 0;
    while (txd === 1'b0) begin lowcnt++; @(negedge clk); end
    check(lowcnt == 16, "R4 start bit 16 ticks", lowcnt, 16);
    repeat (200) @(negedge clk);
    tick_div = 2;
    write_byte(8'hFF);
    while (txd !== 1'b0) @(negedge clk);
    lowcnt = 0;
    while (txd === 1'b0) begin lowcnt++; @(negedge clk); end
    check(lowcnt >= 31 && lowcnt <= 32, "R4 half tick rate", lowcnt, 32);
    repeat (400) @(negedge clk);
    check(txd == 1'b1, "R4 idle line high", txd, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule